// File: doc/BRIEF.md
# Trigger Source Combiner

This block turns a handful of unrelated trigger sources into a single one-clock trigger pulse for an acquisition controller. The sources are one asynchronous external logic input, a threshold check on incoming digitized samples, a bank of eight asynchronous bus trigger lines, a synchronous bus command strobe and a synchronous software strobe. Configuration picks two of these sources and joins them with either OR or AND.

Asynchronous inputs are brought into the clock domain by two flops and then edge-detected. The external input can fire on its rising or its falling edge. Exactly one bus line is monitored, chosen by a selector. The threshold source compares the top eight bits of each 12-bit two's-complement sample against an upper level and a lower level. It fires when the sample leaves the band between them.

Under AND, each of the two chosen sources keeps its event latched until its partner arrives. The trigger goes out on the cycle the second event arrives. A level-sensitive arm input gates the output. Dropping arm discards any latched events.

Top module: `trig_combiner`

## Requirements
- R1: After a synchronous reset, `trig_out` is low and the configuration holds its defaults. The defaults are: both selected sources are software (code 4), OR mode, rising external edge, bus line 0, upper level +127 and lower level -128. With these levels no sample can leave the band.
- R2: `ext_trig_in` passes through a two-flop synchronizer. The active edge is rising when control bit 7 is 0 and falling when it is 1. A change applied before clock edge k produces `trig_out` high after edge k+2. The inactive edge produces nothing.
- R3: Only samples with `sample_valid` high are examined. The signed value `sample_data[11:4]` is out of band when it is strictly greater than the upper level or strictly less than the lower level. An event occurs on an out-of-band sample when the previous valid sample was in band, or when there was no earlier valid sample since reset. `trig_out` follows one edge after that sample.
- R4: All eight `bus_trig_lines` are synchronized by two flops. Only a rising edge on the line picked by control bits [10:8] is an event, with the same latency as R2. Edges on other lines have no effect.
- R5: `bus_cmd_strobe` and `sw_trig_strobe` are synchronous. The rising edge of each is an event, and `trig_out` rises after the same clock edge. A strobe held high produces a single event.
- R6: The source codes are 0 external edge, 1 threshold, 2 bus line, 3 bus command and 4 software. Codes 5 to 7 never produce an event.
- R7: In OR mode (control bit 6 = 0), an event on either selected source fires the trigger.
- R8: In AND mode (control bit 6 = 1), each selected source's event is latched. The trigger fires once, on the cycle the second event arrives or when both arrive together. Both latches clear when it fires.
- R9: While `arm` is low, `trig_out` stays low and events are discarded. A low `arm` also clears both AND latches.
- R10: `trig_out` is never high on two consecutive cycles. A trigger that would fire in the cycle right after a pulse is dropped.
- R11: A write with `cfg_we` high takes effect at the next edge. Address 0 is control, with src_a at [2:0], src_b at [5:3], AND at [6], falling edge at [7] and line select at [10:8]. Address 1 is the upper level [7:0] and address 2 is the lower level [7:0]. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 11 | Configuration write data |
| arm | input | 1 | Level-sensitive arm; output gated while low |
| ext_trig_in | input | 1 | Asynchronous external trigger input |
| bus_trig_lines | input | 8 | Asynchronous bus trigger lines |
| bus_cmd_strobe | input | 1 | Synchronous bus command trigger strobe |
| sw_trig_strobe | input | 1 | Synchronous software trigger strobe |
| sample_valid | input | 1 | Sample qualifier |
| sample_data | input | 12 | Two's-complement sample |
| trig_out | output | 1 | One-clock trigger pulse |

## Verification
The hardest state to reach from the ports is a pending half of an AND pair. At that point one event is latched inside, and the trigger must either fire on the partner's arrival or be wiped by a brief drop of `arm`. Nothing at the outputs shows that latch. The stimulus therefore probes it by delivering the partner event afterwards and observing whether a pulse appears. The bench also places two OR events on back-to-back cycles to reach the suppression case. It steps sample values exactly onto each level and one code past it, so the strict comparison and the excursion tracking can be seen at `trig_out`.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int NSRC    = 5;
    localparam int SEL_W   = 3;
    localparam int NLINES  = 8;
    localparam int LINE_W  = $clog2(NLINES);
    localparam int SAMP_W  = 12;
    localparam int LVL_W   = 8;
    localparam int CFG_AW  = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_EXT     = 3'd0,
        SRC_LEVEL   = 3'd1,
        SRC_BUSLINE = 3'd2,
        SRC_BUSCMD  = 3'd3,
        SRC_SOFT    = 3'd4
    } trig_src_e;

    typedef enum logic [CFG_AW-1:0] {
        REG_CTRL  = 2'd0,
        REG_UPPER = 2'd1,
        REG_LOWER = 2'd2,
        REG_SPARE = 2'd3
    } cfg_reg_e;

    typedef struct packed {
        logic [LINE_W-1:0] line_sel;
        logic              ext_falling;
        logic              op_and;
        logic [SEL_W-1:0]  src_b;
        logic [SEL_W-1:0]  src_a;
    } trig_ctrl_t;

    localparam int CFG_DW = $bits(trig_ctrl_t);

    localparam trig_ctrl_t CTRL_RESET = '{
        line_sel:    '0,
        ext_falling: 1'b0,
        op_and:      1'b0,
        src_b:       SRC_SOFT,
        src_a:       SRC_SOFT
    };

    localparam logic signed [LVL_W-1:0] UPPER_RESET = {1'b0, {(LVL_W-1){1'b1}}};
    localparam logic signed [LVL_W-1:0] LOWER_RESET = {1'b1, {(LVL_W-1){1'b0}}};

    function automatic logic signed [LVL_W-1:0] sample_msbs(input logic [SAMP_W-1:0] s);
        return $signed(s[SAMP_W-1 -: LVL_W]);
    endfunction
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_DW-1:0]        cfg_wdata,
    output trig_ctrl_t               ctrl,
    output logic signed [LVL_W-1:0]  upper,
    output logic signed [LVL_W-1:0]  lower
);
    logic unused_hi;
    assign unused_hi = ^cfg_wdata[CFG_DW-1:LVL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_RESET;
            upper <= UPPER_RESET;
            lower <= LOWER_RESET;
        end else if (cfg_we) begin
            case (cfg_reg_e'(cfg_addr))
                REG_CTRL:  ctrl  <= trig_ctrl_t'(cfg_wdata);
                REG_UPPER: upper <= $signed(cfg_wdata[LVL_W-1:0]);
                REG_LOWER: lower <= $signed(cfg_wdata[LVL_W-1:0]);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1, s2, prev;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                s1[i]   <= 1'b0;
                s2[i]   <= 1'b0;
                prev[i] <= 1'b0;
            end else begin
                s1[i]   <= async_in[i];
                s2[i]   <= s1[i];
                prev[i] <= s2[i];
            end
        end
        assign rise[i] = s2[i] & ~prev[i];
        assign fall[i] = ~s2[i] & prev[i];
    end

    // R2 / R4: a detected edge lasts exactly one cycle
    a_r2_edge_once: assert property (@(posedge clk) disable iff (rst)
        ((rise & $past(rise)) == '0) && ((fall & $past(fall)) == '0));
endmodule

// File: rtl/trig_level_check.sv
module trig_level_check
    import trig_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_valid,
    input  logic [SAMP_W-1:0]       sample_data,
    input  logic signed [LVL_W-1:0] upper,
    input  logic signed [LVL_W-1:0] lower,
    output logic                    evt
);
    logic signed [LVL_W-1:0] msb;
    logic                    out_band;
    logic                    prev_out;
    logic                    unused_lsbs;

    assign unused_lsbs = ^sample_data[SAMP_W-LVL_W-1:0];
    assign msb      = sample_msbs(sample_data);
    assign out_band = (msb > upper) || (msb < lower);
    assign evt      = sample_valid & out_band & ~prev_out;

    always_ff @(posedge clk) begin
        if (rst)               prev_out <= 1'b0;
        else if (sample_valid) prev_out <= out_band;
    end

    // R3: one event per excursion, never on back-to-back cycles
    a_r3_one_per_excursion: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);
endmodule

// File: rtl/trig_merge.sv
module trig_merge
    import trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             holdoff,
    input  logic [NSRC-1:0]  evt,
    input  logic [SEL_W-1:0] src_a,
    input  logic [SEL_W-1:0] src_b,
    input  logic             op_and,
    output logic             fire
);
    localparam int PAD_N = 2 ** SEL_W;

    logic [PAD_N-1:0] evt_pad;
    logic             ev_a, ev_b, seen_a, seen_b, have_a, have_b;

    assign evt_pad = {{(PAD_N-NSRC){1'b0}}, evt};
    assign ev_a    = evt_pad[src_a];
    assign ev_b    = evt_pad[src_b];
    assign have_a  = seen_a | ev_a;
    assign have_b  = seen_b | ev_b;
    assign fire    = arm & ~holdoff & (op_and ? (have_a & have_b) : (ev_a | ev_b));

    always_ff @(posedge clk) begin
        if (rst || !arm || fire) begin
            seen_a <= 1'b0;
            seen_b <= 1'b0;
        end else if (op_and) begin
            if (ev_a) seen_a <= 1'b1;
            if (ev_b) seen_b <= 1'b1;
        end
    end

    // R9: disarming wipes any half-collected AND pair
    a_r9_disarm_clears: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (!seen_a && !seen_b));
    // R8: after firing, no stale latch remains
    a_r8_fire_clears: assert property (@(posedge clk) disable iff (rst)
        fire |=> (!seen_a && !seen_b));
endmodule

// File: rtl/trig_combiner.sv
module trig_combiner
    import trig_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0]     cfg_wdata,
    input  logic                  arm,
    input  logic                  ext_trig_in,
    input  logic [NLINES-1:0]     bus_trig_lines,
    input  logic                  bus_cmd_strobe,
    input  logic                  sw_trig_strobe,
    input  logic                  sample_valid,
    input  logic [SAMP_W-1:0]     sample_data,
    output logic                  trig_out
);
    trig_ctrl_t              ctrl;
    logic signed [LVL_W-1:0] upper, lower;
    logic [NLINES:0]         a_rise, a_fall;
    logic                    lvl_evt, cmd_prev, sw_prev, fire;
    logic [NSRC-1:0]         evt;

    trig_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ctrl(ctrl), .upper(upper), .lower(lower)
    );

    trig_sync_edge #(.W(NLINES + 1)) u_sync (
        .clk(clk), .rst(rst), .async_in({bus_trig_lines, ext_trig_in}),
        .rise(a_rise), .fall(a_fall)
    );

    trig_level_check u_level (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_data(sample_data),
        .upper(upper), .lower(lower), .evt(lvl_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_prev <= 1'b0;
            sw_prev  <= 1'b0;
        end else begin
            cmd_prev <= bus_cmd_strobe;
            sw_prev  <= sw_trig_strobe;
        end
    end

    logic [NLINES-1:0] line_rise;
    logic              unused_fall;
    assign line_rise   = a_rise[NLINES:1];
    assign unused_fall = ^a_fall[NLINES:1];

    always_comb begin
        evt              = '0;
        evt[SRC_EXT]     = ctrl.ext_falling ? a_fall[0] : a_rise[0];
        evt[SRC_LEVEL]   = lvl_evt;
        evt[SRC_BUSLINE] = line_rise[ctrl.line_sel];
        evt[SRC_BUSCMD]  = bus_cmd_strobe & ~cmd_prev;
        evt[SRC_SOFT]    = sw_trig_strobe & ~sw_prev;
    end

    trig_merge u_merge (
        .clk(clk), .rst(rst), .arm(arm), .holdoff(trig_out), .evt(evt),
        .src_a(ctrl.src_a), .src_b(ctrl.src_b), .op_and(ctrl.op_and), .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (rst) trig_out <= 1'b0;
        else     trig_out <= fire;
    end

    // R9: a pulse only follows a cycle with arm high
    a_r9_arm_gate: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> $past(arm));
    // R10: the pulse is one clock wide
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);
endmodule

// File: tb/trig_combiner_bench.sv
module trig_combiner_bench;
    import trig_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [CFG_DW-1:0] cfg_wdata = '0;
    logic              arm = 1'b0;
    logic              ext_trig_in = 1'b0;
    logic [NLINES-1:0] bus_trig_lines = '0;
    logic              bus_cmd_strobe = 1'b0;
    logic              sw_trig_strobe = 1'b0;
    logic              sample_valid = 1'b0;
    logic [SAMP_W-1:0] sample_data = '0;
    logic              trig_out;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    trig_combiner u_trig_combiner (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .arm(arm), .ext_trig_in(ext_trig_in), .bus_trig_lines(bus_trig_lines),
        .bus_cmd_strobe(bus_cmd_strobe), .sw_trig_strobe(sw_trig_strobe),
        .sample_valid(sample_valid), .sample_data(sample_data), .trig_out(trig_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (trig_out === 1'b1) pulses++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic [CFG_DW-1:0] ctrl_word(input int a, input int b,
                                                    input bit op_and, input bit fall, input int line);
        trig_ctrl_t c;
        c.src_a = SEL_W'(a);
        c.src_b = SEL_W'(b);
        c.op_and = op_and;
        c.ext_falling = fall;
        c.line_sel = LINE_W'(line);
        return c;
    endfunction

    task automatic write_cfg(input int addr, input logic [CFG_DW-1:0] data);
        cfg_we = 1'b1; cfg_addr = CFG_AW'(addr); cfg_wdata = data;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rearm();
        arm = 1'b0; tick(); arm = 1'b1;
    endtask

    task automatic strobe_sw();
        sw_trig_strobe = 1'b1; tick(); sw_trig_strobe = 1'b0;
    endtask

    task automatic strobe_cmd();
        bus_cmd_strobe = 1'b1; tick(); bus_cmd_strobe = 1'b0;
    endtask

    task automatic feed(input logic [SAMP_W-1:0] s, input bit valid);
        sample_valid = valid; sample_data = s; tick(); sample_valid = 1'b0;
    endtask

    task automatic t_reset_defaults();
        int p0;
        check(trig_out === 1'b0, "R1 out low after reset", int'(trig_out), 0);
        arm = 1'b1;
        p0 = pulses;
        ext_trig_in = 1'b1; bus_trig_lines = '1; bus_cmd_strobe = 1'b1;
        feed(12'h7FF, 1'b1); feed(12'h800, 1'b1);
        ext_trig_in = 1'b0; bus_trig_lines = '0; bus_cmd_strobe = 1'b0;
        tick(5);
        check(pulses == p0, "R1 non-default sources idle", pulses - p0, 0);
        strobe_sw();
        check(trig_out === 1'b1, "R1 default software source", int'(trig_out), 1);
    endtask

    task automatic t_strobes();
        int p0;
        tick();
        p0 = pulses;
        sw_trig_strobe = 1'b1; tick();
        check(trig_out === 1'b1, "R5 sw strobe next edge", int'(trig_out), 1);
        tick(3);
        sw_trig_strobe = 1'b0;
        check(pulses - p0 == 1, "R5 held strobe one event", pulses - p0, 1);
        write_cfg(0, ctrl_word(3, 7, 0, 0, 0));
        strobe_cmd();
        check(trig_out === 1'b1, "R5 bus command strobe", int'(trig_out), 1);
    endtask

    task automatic t_ext_edge();
        int p0;
        write_cfg(0, ctrl_word(0, 7, 0, 0, 0));
        tick();
        ext_trig_in = 1'b1;
        tick(2);
        check(trig_out === 1'b0, "R2 not before sync delay", int'(trig_out), 0);
        tick();
        check(trig_out === 1'b1, "R2 rising edge at k+2", int'(trig_out), 1);
        p0 = pulses;
        ext_trig_in = 1'b0; tick(5);
        check(pulses == p0, "R2 falling ignored when rising", pulses - p0, 0);
        write_cfg(0, ctrl_word(0, 7, 0, 1, 0));
        p0 = pulses;
        ext_trig_in = 1'b1; tick(5);
        check(pulses == p0, "R2 rising ignored when falling", pulses - p0, 0);
        ext_trig_in = 1'b0; tick(3);
        check(trig_out === 1'b1, "R2 falling edge fires", int'(trig_out), 1);
    endtask

    task automatic t_bus_line();
        int p0;
        write_cfg(0, ctrl_word(2, 7, 0, 0, 5));
        p0 = pulses;
        bus_trig_lines[3] = 1'b1; tick(5);
        check(pulses == p0, "R4 unselected line ignored", pulses - p0, 0);
        bus_trig_lines[5] = 1'b1; tick(2);
        check(trig_out === 1'b0, "R4 not before sync delay", int'(trig_out), 0);
        tick();
        check(trig_out === 1'b1, "R4 selected line fires", int'(trig_out), 1);
        bus_trig_lines = '0; tick(3);
    endtask

    task automatic t_threshold();
        int p0;
        write_cfg(1, CFG_DW'(8'h40));
        write_cfg(2, CFG_DW'(8'hC0));
        write_cfg(0, ctrl_word(1, 7, 0, 0, 0));
        p0 = pulses;
        feed(12'h40F, 1'b1);
        check(trig_out === 1'b0, "R3 equal to upper no fire", int'(trig_out), 0);
        feed(12'hC00, 1'b1);
        check(trig_out === 1'b0, "R3 equal to lower no fire", int'(trig_out), 0);
        feed(12'h7F0, 1'b0);
        check(trig_out === 1'b0, "R3 invalid sample ignored", int'(trig_out), 0);
        feed(12'h410, 1'b1);
        check(trig_out === 1'b1, "R3 above upper fires", int'(trig_out), 1);
        feed(12'h500, 1'b1);
        check(trig_out === 1'b0, "R3 same excursion no refire", int'(trig_out), 0);
        feed(12'h000, 1'b1);
        feed(12'hBF0, 1'b1);
        check(trig_out === 1'b1, "R3 below lower fires", int'(trig_out), 1);
        tick(2);
        check(pulses - p0 == 2, "R3 excursion count", pulses - p0, 2);
    endtask

    task automatic t_or_and();
        int p0;
        write_cfg(0, ctrl_word(3, 4, 0, 0, 0));
        p0 = pulses;
        strobe_cmd(); tick(2); strobe_sw(); tick(2);
        check(pulses - p0 == 2, "R7 OR either source", pulses - p0, 2);
        write_cfg(0, ctrl_word(3, 4, 1, 0, 0));
        rearm();
        p0 = pulses;
        strobe_cmd();
        tick(3);
        check(pulses == p0, "R8 AND single source waits", pulses - p0, 0);
        strobe_sw();
        check(trig_out === 1'b1, "R8 AND fires on second event", int'(trig_out), 1);
        tick(2);
        strobe_sw(); tick(3);
        check(pulses - p0 == 1, "R8 latches cleared after fire", pulses - p0, 1);
        strobe_cmd();
        check(trig_out === 1'b1, "R8 latched partner completes", int'(trig_out), 1);
        tick(2);
        bus_cmd_strobe = 1'b1; sw_trig_strobe = 1'b1; tick();
        bus_cmd_strobe = 1'b0; sw_trig_strobe = 1'b0;
        check(trig_out === 1'b1, "R8 simultaneous events fire", int'(trig_out), 1);
        tick(2);
    endtask

    task automatic t_arm();
        int p0;
        p0 = pulses;
        arm = 1'b0;
        strobe_cmd(); tick();
        arm = 1'b1;
        strobe_sw(); tick(3);
        check(pulses == p0, "R9 event while disarmed discarded", pulses - p0, 0);
        rearm();
        strobe_cmd(); tick();
        arm = 1'b0; tick(); arm = 1'b1;
        strobe_sw(); tick(3);
        check(pulses == p0, "R9 disarm clears latch", pulses - p0, 0);
        rearm();
        write_cfg(0, ctrl_word(3, 4, 0, 0, 0));
        arm = 1'b0;
        strobe_sw(); tick(3);
        check(pulses == p0, "R9 OR gated by arm", pulses - p0, 0);
        arm = 1'b1; tick();
    endtask

    task automatic t_single_pulse();
        int p0;
        p0 = pulses;
        bus_cmd_strobe = 1'b1; tick();
        bus_cmd_strobe = 1'b0; sw_trig_strobe = 1'b1; tick();
        sw_trig_strobe = 1'b0;
        check(trig_out === 1'b0, "R10 back-to-back suppressed", int'(trig_out), 0);
        tick(3);
        check(pulses - p0 == 1, "R10 one pulse total", pulses - p0, 1);
    endtask

    task automatic t_cfg_and_codes();
        int p0;
        write_cfg(3, ctrl_word(5, 6, 0, 0, 0));
        strobe_sw();
        check(trig_out === 1'b1, "R11 spare address ignored", int'(trig_out), 1);
        write_cfg(0, ctrl_word(5, 6, 0, 0, 0));
        p0 = pulses;
        strobe_sw(); tick(); strobe_cmd(); tick();
        ext_trig_in = 1'b1; bus_trig_lines = '1; tick(4);
        feed(12'h7F0, 1'b1); tick(2);
        check(pulses == p0, "R6 unused codes never fire", pulses - p0, 0);
        write_cfg(0, ctrl_word(7, 4, 0, 0, 0));
        strobe_sw();
        check(trig_out === 1'b1, "R11 control write takes effect", int'(trig_out), 1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        t_reset_defaults();
        t_strobes();
        t_ext_edge();
        t_bus_line();
        t_threshold();
        t_or_and();
        t_arm();
        t_single_pulse();
        t_cfg_and_codes();
        tick(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule